// File: doc/BRIEF.md
# Nested Carry-Select Adder

A purely combinational 16-bit adder that returns `{carry_out, sum} = op_a + op_b + carry_in`. The word is cut into four 4-bit slices. The lowest slice is a plain ripple adder fed by the external carry. The second slice is built twice, once assuming an incoming carry of 0 and once of 1. The carry leaving the lowest slice then picks one of the two results.

The upper byte repeats this whole 8-bit arrangement inside two complete copies. One copy has its carry-in tied low and the other tied high. The carry leaving bit 7 chooses between the two copies for both the upper sum byte and the final carry-out.

No block carry is rippled through a slice. Each one is formed from the two conditional carry-outs of the slice it leaves. The carry-out of the assume-0 copy acts as the block generate and the carry-out of the assume-1 copy acts as the block propagate, so `c_next = G | (P & c_in)`. The worst path is therefore one 4-bit ripple followed by one selector per nesting level.

Top module: `csel_adder16`

## Requirements
- R1: For every input combination, `{carry_out, sum}` equals the 17-bit arithmetic value `op_a + op_b + carry_in`.
- R2: `sum[3:0]` equals the low four bits of `op_a[3:0] + op_b[3:0] + carry_in`, whatever the upper operand bits are.
- R3: When `op_a[15]` and `op_b[15]` are both 1, `carry_out` is 1.
- R4: When `op_a[15]` and `op_b[15]` are both 0, `carry_out` is 0.
- R5: When the operands are bitwise complements of each other, the carry-in passes through the whole word: `sum` is all ones if `carry_in` is 0 and all zeros if it is 1, and `carry_out` equals `carry_in`.
- R6: All ones plus one gives `sum = 16'h0000` with `carry_out = 1`, both as `16'hFFFF + 16'h0001` and as `16'hFFFF + 16'h0000` with `carry_in = 1`.
- R7: Zero plus zero with `carry_in = 1` gives `sum = 16'h0001` and `carry_out = 0`.
- R8: A carry produced below a slice boundary (out of bit 3, 7 or 11) reaches the next slice. For example, `16'h000F + 1 = 16'h0010`, `16'h00FF + 1 = 16'h0100` and `16'h0FFF + 1 = 16'h1000`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The first sweep runs both low bytes through all 65,536 pairs. The upper bytes follow derived patterns and the carry-in alternates, which exercises every case of the bit-7 selection and of the inner bits-7:4 selection.

The second sweep runs both upper bytes through all pairs while the low bytes are chosen so that the carry out of bit 7 toggles. This tells apart the two nested 8-bit copies and their own inner selection.

Named corner vectors cover the cases that a swapped selector or a wrong generate/propagate term would break: full carry propagation, all ones plus one, zero plus carry-in, and carries crossing each slice boundary.

// File: rtl/csel_adder16.sv
module csel_adder16 #(
  parameter int BLK = 4,
  localparam int W = 4 * BLK
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out
);

  function automatic logic [BLK:0] rca(input logic [BLK-1:0] x,
                                       input logic [BLK-1:0] y,
                                       input logic ci);
    logic c;
    logic [BLK-1:0] s;
    c = ci;
    s = '0;
    for (int i = 0; i < BLK; i++) begin
      s[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | ((x[i] ^ y[i]) & c);
    end
    return {c, s};
  endfunction

  logic [BLK:0] lo, mid0, mid1;
  logic         c_lo, c_mid;

  assign lo    = rca(op_a[BLK-1:0], op_b[BLK-1:0], carry_in);
  assign c_lo  = lo[BLK];
  assign mid0  = rca(op_a[2*BLK-1:BLK], op_b[2*BLK-1:BLK], 1'b0);
  assign mid1  = rca(op_a[2*BLK-1:BLK], op_b[2*BLK-1:BLK], 1'b1);
  assign c_mid = mid0[BLK] | (mid1[BLK] & c_lo);

  logic [1:0][2*BLK-1:0] up_sum;
  logic [1:0]            up_c;

  for (genvar k = 0; k < 2; k++) begin : g_upper
    logic [BLK:0] ul, uh0, uh1;
    assign ul  = rca(op_a[3*BLK-1:2*BLK], op_b[3*BLK-1:2*BLK], 1'(k));
    assign uh0 = rca(op_a[W-1:3*BLK], op_b[W-1:3*BLK], 1'b0);
    assign uh1 = rca(op_a[W-1:3*BLK], op_b[W-1:3*BLK], 1'b1);
    assign up_sum[k] = {(ul[BLK] ? uh1[BLK-1:0] : uh0[BLK-1:0]), ul[BLK-1:0]};
    assign up_c[k]   = uh0[BLK] | (uh1[BLK] & ul[BLK]);
  end

  assign sum = {(c_mid ? up_sum[1] : up_sum[0]),
                (c_lo ? mid1[BLK-1:0] : mid0[BLK-1:0]),
                lo[BLK-1:0]};
  assign carry_out = up_c[0] | (up_c[1] & c_mid);

endmodule

module csel_adder16_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         carry_in,
  input logic [W-1:0] sum,
  input logic         carry_out
);
  logic [W:0] ref_total;
  logic [4:0] ref_nib;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
  assign ref_nib   = {1'b0, op_a[3:0]} + {1'b0, op_b[3:0]} + {4'b0, carry_in};

  always_comb begin
    AST_FULL_SUM: assert ({carry_out, sum} == ref_total);                 // R1
    AST_LOW_NIBBLE: assert (sum[3:0] == ref_nib[3:0]);                    // R2
    AST_MSB_GENERATE: assert (!(op_a[W-1] & op_b[W-1]) || carry_out);     // R3
    AST_MSB_KILL: assert ((op_a[W-1] | op_b[W-1]) || !carry_out);         // R4
    AST_FULL_PROPAGATE: assert ((op_a ^ op_b) != {W{1'b1}} ||
                                (sum == {W{~carry_in}} && carry_out == carry_in)); // R5
  end
endmodule

bind csel_adder16 csel_adder16_chk #(.W(W)) chk_i (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum(sum), .carry_out(carry_out)
);

// File: tb/csel_adder16_test.sv
module csel_adder16_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic [15:0] a, b, s;
  logic        ci, co;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  csel_adder16 uut (.op_a(a), .op_b(b), .carry_in(ci), .sum(s), .carry_out(co));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic apply(input logic [15:0] va, input logic [15:0] vb,
                       input logic vc, input string tag);
    logic [16:0] exp;
    @(posedge clk);
    a = va; b = vb; ci = vc;
    @(negedge clk);
    exp = {1'b0, va} + {1'b0, vb} + {16'b0, vc};
    n_chk++;
    if ({co, s} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%0b got %h expected %h", tag, va, vb, vc, {co, s}, exp);
    end
  endtask

  task automatic apply_nib(input logic [15:0] va, input logic [15:0] vb, input logic vc);
    logic [4:0] exp;
    @(posedge clk);
    a = va; b = vb; ci = vc;
    @(negedge clk);
    exp = {1'b0, va[3:0]} + {1'b0, vb[3:0]} + {4'b0, vc};
    n_chk++;
    if (s[3:0] !== exp[3:0]) begin
      n_fail++;
      $display("FAIL R2: low nibble got %h expected %h", s[3:0], exp[3:0]);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    apply(16'h0000, 16'h0000, 1'b0, "R1 zero");
    apply(16'h0000, 16'h0000, 1'b1, "R7 zero plus carry");
    apply(16'hFFFF, 16'h0001, 1'b0, "R6 ones plus one");
    apply(16'hFFFF, 16'h0000, 1'b1, "R6 ones plus carry");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R6 ones plus ones");
    apply(16'hAAAA, 16'h5555, 1'b0, "R5 alternating cin0");
    apply(16'hAAAA, 16'h5555, 1'b1, "R5 alternating cin1");
    apply(16'h5555, 16'h5555, 1'b1, "R1 alternating same");
    apply(16'h000F, 16'h0001, 1'b0, "R8 bit3 boundary");
    apply(16'h00FF, 16'h0001, 1'b0, "R8 bit7 boundary");
    apply(16'h0FFF, 16'h0001, 1'b0, "R8 bit11 boundary");
    apply(16'h00F0, 16'h0010, 1'b0, "R8 mid slice carry");
    apply(16'h8000, 16'h8000, 1'b0, "R3 msb generate");
    apply(16'h7FFF, 16'h0000, 1'b1, "R4 msb kill");
    apply_nib(16'hF3A7, 16'h0C51, 1'b1);
    apply_nib(16'h0007, 16'hFFF8, 1'b0);
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        apply({8'(i * 37), 8'(i)}, {8'(~j), 8'(j)}, 1'((i ^ j) & 1), "R1 low sweep");
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        apply({8'(i), 8'hFF}, {8'(j), 7'b0, 1'((i + j) & 1)}, 1'((j >> 1) & 1), "R1 high sweep");
    done = 1;
    report();
  end
endmodule